// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of two-bit saturating counters, one per entry, and selects an entry from a slice of the branch address. A fetch stage presents a branch address on the lookup port and gets a taken/not-taken guess back in the same cycle, together with the raw counter state. When the branch resolves later in the pipeline, the resolved address and outcome go to the update port, which moves that entry's counter one step toward the outcome.

Entries carry no ownership tag, so distinct branches whose addresses select the same entry share one counter and disturb each other's state. After reset every entry holds the weakly-taken value. Because the table is a plain memory without a bulk reset, a walker rewrites every entry in turn after reset. While it runs, a busy flag is high, lookups report the weakly-taken state and updates are dropped.

Top module: `bimodal_dir_predictor`

## Requirements
- R1: The entry index is branch address bits [12:2]. Address bits [1:0] and bits 13 and above do not affect which entry is chosen, so two addresses equal in bits [12:2] share one counter.
- R2: An update whose outcome is taken raises the selected counter by one, and an update whose outcome is not taken lowers it by one, when the counter is not at a limit.
- R3: Counters saturate: a taken update at 3 leaves 3, and a not-taken update at 0 leaves 0.
- R4: `lk_ctr` shows the selected counter in the same cycle as `lk_pc`, and `lk_taken` is 1 exactly when that value is 2 or 3.
- R5: After reset every entry holds 2. `init_busy` is high during reset and for exactly 2048 clock cycles after the last cycle with `rst` high, then falls to 0.
- R6: While `init_busy` is high, `lk_ctr` reads 2 and `lk_taken` reads 1 for every address, and updates change no entry.
- R7: When a lookup and an update select the same entry in one cycle, the lookup shows the value from before the update. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Branch address to look up |
| lk_taken | output | 1 | Predicted direction, 1 means taken |
| lk_ctr | output | 2 | Counter state of the looked-up entry |
| upd_valid | input | 1 | Resolved branch present on the update port |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 means taken |
| init_busy | output | 1 | High while the table is being initialised |

## Verification
Counters are trained with runs of one outcome long enough to reach each limit, then with a single opposite outcome. This separates saturation from wrap-around, and the threshold from an off-by-one in the update step. Address pairs that differ only in the offset bits or above bit 12 are checked to share state, and an adjacent index is checked to stay untouched, which exposes a shifted index slice. A lookup and an update on one entry in the same cycle tell apart read-before-write from write-through. A reset issued after training, with updates sent during the walk, shows that the busy window has the exact length, forces the weakly-taken answer and drops writes.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MIN  = 2'd0;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_INIT = 2'd2;
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 11,
  parameter int LSB   = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[LSB +: IDX_W];
endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step
  import bp_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    nxt = cur;
    if (taken) begin
      if (cur != CTR_MAX) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_MIN) nxt = cur - 2'd1;
    end
  end
endmodule

// File: rtl/bp_init_walk.sv
module bp_init_walk #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] walk_idx
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      walk_idx <= '0;
    end else if (busy) begin
      walk_idx <= walk_idx + 1'b1;
      if (walk_idx == LAST) busy <= 1'b0;
    end
  end

  // R5: the walk ends only after the final entry was written
  p_walk_end_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(walk_idx) == LAST);

  // R5: once idle, the walker stays idle until the next reset
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);
endmodule

// File: rtl/bimodal_dir_predictor.sv
module bimodal_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 11,
  parameter int IDX_LSB = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [1:0]      lk_ctr,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            init_busy
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0] lk_idx, upd_idx, walk_idx;
  ctr_t             upd_cur, upd_nxt, lk_raw;
  logic             busy, upd_fire;

  ctr_t table_q [ENTRIES];

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(IDX_LSB)) u_lk_index (
    .pc(lk_pc), .idx(lk_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(IDX_LSB)) u_upd_index (
    .pc(upd_pc), .idx(upd_idx));

  bp_init_walk #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst(rst), .busy(busy), .walk_idx(walk_idx));

  assign upd_cur  = table_q[upd_idx];
  assign upd_fire = upd_valid && !busy;

  bp_sat_step u_step (.cur(upd_cur), .taken(upd_taken), .nxt(upd_nxt));

  // single write port: the walker owns it while busy
  always_ff @(posedge clk) begin
    if (busy)          table_q[walk_idx] <= CTR_INIT;
    else if (upd_fire) table_q[upd_idx]  <= upd_nxt;
  end

  // asynchronous read returns the pre-update value on a same-entry clash
  assign lk_raw    = table_q[lk_idx];
  assign lk_ctr    = busy ? CTR_INIT : lk_raw;
  assign lk_taken  = lk_ctr[1];
  assign init_busy = busy;

  // R3: no wrap at the top
  p_sat_top_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && upd_taken && upd_cur == CTR_MAX) |-> upd_nxt == CTR_MAX);

  // R3: no wrap at the bottom
  p_sat_bot_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_taken && upd_cur == CTR_MIN) |-> upd_nxt == CTR_MIN);

  // R2: one step per update away from the limits
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && upd_taken && upd_cur != CTR_MAX) |-> upd_nxt == upd_cur + 2'd1);
  p_step_dn_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_taken && upd_cur != CTR_MIN) |-> upd_nxt == upd_cur - 2'd1);

  // R7: the update lands in the table one cycle later
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && lk_pc == upd_pc) |=> table_q[$past(upd_idx)] == $past(upd_nxt));

  // R6: lookups during initialisation report weakly taken
  p_busy_taken_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lk_taken && lk_ctr == CTR_INIT));
endmodule

// File: tb/test_bimodal_dir_predictor.sv
module test_bimodal_dir_predictor;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic [1:0]  lk_ctr;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic        init_busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bimodal_dir_predictor i_bimodal_dir_predictor (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_ctr(lk_ctr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .init_busy(init_busy));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // look up pc and compare counter and prediction
  task automatic look(input string req, input logic [31:0] pc, input int exp_ctr);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check({req, " ctr"}, lk_ctr, exp_ctr);
    check({req, " taken"}, lk_taken, exp_ctr >= 2);
  endtask

  task automatic train(input logic [31:0] pc, input logic t, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    end
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // R5: exact busy window and initial contents
  task automatic t_reset_walk();
    int n = 0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R5 busy during reset", init_busy, 1);
    @(negedge clk); rst = 1'b0;
    while (init_busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check("R5 busy length", n, 2048);
    look("R5 init idx0", 32'h0000_0000, 2);
    look("R5 init idx2047", 32'h0000_1FFC, 2);
    look("R5 init mid", 32'h0000_0A50, 2);
  endtask

  // R2 R4: stepping and threshold
  task automatic t_steps();
    train(32'h0000_0040, 1'b0, 1); look("R2 dec 2->1 R4", 32'h0000_0040, 1);
    train(32'h0000_0040, 1'b0, 1); look("R2 dec 1->0", 32'h0000_0040, 0);
    train(32'h0000_0040, 1'b1, 1); look("R2 inc 0->1", 32'h0000_0040, 1);
    train(32'h0000_0040, 1'b1, 1); look("R4 inc 1->2 taken", 32'h0000_0040, 2);
    train(32'h0000_0040, 1'b1, 1); look("R4 inc 2->3", 32'h0000_0040, 3);
  endtask

  // R3: saturation both ends
  task automatic t_saturate();
    train(32'h0000_0020, 1'b1, 5); look("R3 top hold", 32'h0000_0020, 3);
    train(32'h0000_0020, 1'b0, 1); look("R3 top then dec", 32'h0000_0020, 2);
    train(32'h0000_0024, 1'b0, 5); look("R3 bottom hold", 32'h0000_0024, 0);
    train(32'h0000_0024, 1'b1, 1); look("R3 bottom then inc", 32'h0000_0024, 1);
  endtask

  // R1: aliasing through the index slice
  task automatic t_alias();
    train(32'h0000_0010, 1'b1, 1);
    look("R1 alias bit13 and offset", 32'h0000_2012, 3);
    look("R1 alias high bits", 32'hFFFF_E013, 3);
    look("R1 neighbour untouched", 32'h0000_0014, 2);
    look("R1 lower neighbour untouched", 32'h0000_000C, 2);
    train(32'h8000_0011, 1'b0, 2);
    look("R1 shared counter lowered", 32'h0000_0010, 1);
  endtask

  // R7: same-cycle lookup and update
  task automatic t_same_cycle();
    @(negedge clk);
    lk_pc = 32'h0000_0100;
    upd_valid = 1'b1; upd_pc = 32'h0000_0100; upd_taken = 1'b0;
    #1;
    check("R7 old value seen", lk_ctr, 2);
    check("R7 old prediction", lk_taken, 1);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    check("R7 new value next cycle", lk_ctr, 1);
  endtask

  // R6: lookups forced taken and updates dropped during the walk
  task automatic t_busy_block();
    train(32'h0000_1FFC, 1'b0, 2);
    look("R6 trained before reset", 32'h0000_1FFC, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R6 busy lookup forced", 32'h0000_1FFC, 2);
    repeat (5) @(negedge clk);
    train(32'h0000_0000, 1'b0, 3);
    check("R6 still busy", init_busy, 1);
    while (init_busy) @(negedge clk);
    look("R6 update during busy dropped", 32'h0000_0000, 2);
    look("R5 re-init after training", 32'h0000_1FFC, 2);
  endtask

  initial begin
    rst = 1'b1; lk_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    t_reset_walk();
    t_steps();
    t_saturate();
    t_alias();
    t_same_cycle();
    t_busy_block();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule